// File: doc/BRIEF.md
# Fixed-Width Trigger Pulse Regenerator

This block takes a raw, asynchronous trigger line and turns every clean rising edge into an output pulse of a set number of system clock cycles. The trigger first goes through a two-stage synchroniser. A glitch filter then accepts a change of level only when the synchronised value has held for a set number of cycles.

In fixed-width mode, a filtered low-to-high transition starts a pulse of `PULSE_W` cycles. After the pulse comes a hold-off window, during which further edges are discarded. Pulse plus hold-off lasts `DUTY_DIV * PULSE_W` cycles, so the output rate can never exceed one pulse per that many cycles. A `busy_o` flag is high for the whole of this window.

When the compile-time switch `FIXED_WIDTH` is cleared, the output simply copies the filtered input, and the width and hold-off settings do nothing. Elaboration stops if `PULSE_W` is outside 20..40 or if `DUTY_DIV` is below 2.

Top module: `trig_pulse_shaper`

## Requirements
- R1: A synchronous active-high reset drives `pulse_o` and `busy_o` low on the next clock edge, even in the middle of a pulse. After release, a new trigger is accepted normally.
- R2: A change of the synchronised trigger is taken only after it has held for `GLITCH_LEN` consecutive cycles (default 3). A high or low excursion of fewer cycles has no effect on the output, in either mode.
- R3: In fixed-width mode, `pulse_o` goes high `GLITCH_LEN + 3` cycles after the first clock edge that samples the trigger high.
- R4: In fixed-width mode, every output pulse is high for exactly `PULSE_W` consecutive cycles (default 24).
- R5: `busy_o` rises together with `pulse_o` and stays high for exactly `PULSE_W * DUTY_DIV` cycles (default 96). This window covers the pulse and the hold-off.
- R6: A filtered rising edge that lands while `busy_o` is high is discarded. One that lands in the first cycle after `busy_o` falls starts a new pulse.
- R7: A trigger held high produces only one pulse, however long it is held.
- R8: With `FIXED_WIDTH` = 0, `pulse_o` copies the filtered trigger with a latency of `GLITCH_LEN + 2` cycles and the same high time. `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Raw asynchronous trigger |
| pulse_o | output | 1 | Regenerated pulse (registered) |
| busy_o | output | 1 | High during pulse and hold-off window (registered) |

## Verification
The bench sends a second trigger edge exactly one cycle before, and exactly one cycle after, the end of the hold-off window. An off-by-one in the hold-off counter would either drop the legal pulse or let the early one through. Trigger bursts one cycle shorter than the filter length, and short dropouts inside a high level, expose a filter that counts one cycle too few or restarts wrongly; such a filter would emit spurious pulses. A long held trigger catches a controller that retriggers on level rather than edge, and a reset asserted mid-pulse catches outputs that linger after reset.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PULSE  = 2'd1,
    ST_REJECT = 2'd2
  } pgen_state_e;

  // bits needed to count up to n-1 (at least one)
  function automatic int cnt_bits(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pgen_sync.sv
module pgen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) chain_q <= '0;
    else       chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pgen_glitch_filter.sv
module pgen_glitch_filter
  import pgen_pkg::*;
#(
  parameter int LEN = 3
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = cnt_bits(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] run_q;
  logic          level_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q   <= '0;
      level_q <= 1'b0;
    end else if (d_i == level_q) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      level_q <= d_i;
      run_q   <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign q_o = level_q;
endmodule

// File: rtl/pgen_fw_ctrl.sv
module pgen_fw_ctrl
  import pgen_pkg::*;
#(
  parameter int PULSE_W  = 24,
  parameter int DUTY_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lvl_i,
  output logic pulse_o,
  output logic busy_o
);
  localparam int REJ_CYC = PULSE_W * (DUTY_DIV - 1);
  localparam int CW      = cnt_bits(PULSE_W * DUTY_DIV);
  localparam logic [CW-1:0] W_LAST   = CW'(PULSE_W - 1);
  localparam logic [CW-1:0] REJ_LAST = CW'(REJ_CYC - 1);

  pgen_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic          lvl_d_q;
  logic          pulse_q;
  logic          busy_q;
  logic          rise;

  assign rise = lvl_i & ~lvl_d_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lvl_d_q <= 1'b0;
      pulse_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      lvl_d_q <= lvl_i;
      case (state_q)
        ST_IDLE: begin
          if (rise) begin
            state_q <= ST_PULSE;
            cnt_q   <= '0;
            pulse_q <= 1'b1;
            busy_q  <= 1'b1;
          end
        end
        ST_PULSE: begin
          if (cnt_q == W_LAST) begin
            state_q <= ST_REJECT;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_REJECT: begin
          if (cnt_q == REJ_LAST) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
          pulse_q <= 1'b0;
          busy_q  <= 1'b0;
        end
      endcase
    end
  end

  assign pulse_o = pulse_q;
  assign busy_o  = busy_q;
endmodule

// File: rtl/trig_pulse_shaper.sv
module trig_pulse_shaper #(
  parameter bit FIXED_WIDTH = 1'b1,
  parameter int PULSE_W     = 24,
  parameter int DUTY_DIV    = 4,
  parameter int GLITCH_LEN  = 3
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic trig_i,
  output logic pulse_o,
  output logic busy_o
);
  localparam int SYNC_STAGES = 2;

  if (PULSE_W < 20 || PULSE_W > 40) begin : g_bad_width
    $error("trig_pulse_shaper: PULSE_W must lie in 20..40");
  end
  if (DUTY_DIV < 2) begin : g_bad_div
    $error("trig_pulse_shaper: DUTY_DIV must be at least 2");
  end

  logic trig_sync;
  logic trig_filt;

  pgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (trig_i),
    .q_o   (trig_sync)
  );

  pgen_glitch_filter #(.LEN(GLITCH_LEN)) u_filt (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (trig_sync),
    .q_o   (trig_filt)
  );

  if (FIXED_WIDTH) begin : g_fixed
    pgen_fw_ctrl #(.PULSE_W(PULSE_W), .DUTY_DIV(DUTY_DIV)) u_ctrl (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .lvl_i   (trig_filt),
      .pulse_o (pulse_o),
      .busy_o  (busy_o)
    );
  end else begin : g_pass
    assign pulse_o = trig_filt;
    assign busy_o  = 1'b0;
  end
endmodule

// File: rtl/trig_pulse_shaper_chk.sv
module trig_pulse_shaper_chk #(
  parameter bit FIXED_WIDTH = 1'b1,
  parameter int PULSE_W     = 24,
  parameter int DUTY_DIV    = 4
) (
  input logic clk_i,
  input logic rst_i,
  input logic pulse_o,
  input logic busy_o
);
  logic [15:0] pw_cnt;
  logic [15:0] bw_cnt;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pw_cnt <= '0;
      bw_cnt <= '0;
    end else begin
      pw_cnt <= pulse_o ? pw_cnt + 16'd1 : 16'd0;
      bw_cnt <= busy_o  ? bw_cnt + 16'd1 : 16'd0;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!pulse_o && !busy_o)); // R1

  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
    (FIXED_WIDTH && $fell(pulse_o) && !$past(rst_i)) |-> (pw_cnt == 16'(PULSE_W))); // R4

  AST_PULSE_IN_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
    (FIXED_WIDTH && pulse_o) |-> busy_o); // R5

  AST_BUSY_STARTS_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
    (FIXED_WIDTH && $rose(busy_o)) |-> pulse_o); // R5

  AST_BUSY_WINDOW: assert property (@(posedge clk_i) disable iff (rst_i)
    (FIXED_WIDTH && $fell(busy_o) && !$past(rst_i)) |-> (bw_cnt == 16'(PULSE_W * DUTY_DIV))); // R5

  AST_START_FROM_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (FIXED_WIDTH && $rose(pulse_o)) |-> $past(!busy_o)); // R6

  AST_PT_NO_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
    !FIXED_WIDTH |-> !busy_o); // R8
endmodule

bind trig_pulse_shaper trig_pulse_shaper_chk #(
  .FIXED_WIDTH (FIXED_WIDTH),
  .PULSE_W     (PULSE_W),
  .DUTY_DIV    (DUTY_DIV)
) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .pulse_o (pulse_o),
  .busy_o  (busy_o)
);

// File: tb/trig_pulse_shaper_bench.sv
module trig_pulse_shaper_bench;
  localparam int W   = 24;
  localparam int D   = 4;
  localparam int GL  = 3;
  localparam int NV  = 7;
  // hi1, lo1, hi2, exp rises, exp pulse-high cycles, exp busy cycles, exp pass-through high cycles
  localparam int VEC [NV][7] = '{
    '{2,   0,  0, 0, 0,   0,     0},   // R2 too short
    '{3,   0,  0, 1, W,   W*D,   3},   // R2 exactly long enough
    '{200, 0,  0, 1, W,   W*D,   200}, // R7 held high
    '{5,  91,  5, 1, W,   W*D,   10},  // R6 one cycle early
    '{5,  92,  5, 2, 2*W, 2*W*D, 10},  // R6 first legal cycle
    '{4,   2,  4, 1, W,   W*D,   10},  // R2 short dropout
    '{6,  30,  6, 1, W,   W*D,   12}   // R6 inside hold-off
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0;
  logic pulse, busy, pt_pulse, pt_busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trig_pulse_shaper #(.FIXED_WIDTH(1'b1), .PULSE_W(W), .DUTY_DIV(D), .GLITCH_LEN(GL))
  u_trig_pulse_shaper (.clk_i(clk), .rst_i(rst), .trig_i(trig), .pulse_o(pulse), .busy_o(busy));

  trig_pulse_shaper #(.FIXED_WIDTH(1'b0), .PULSE_W(W), .DUTY_DIV(D), .GLITCH_LEN(GL))
  u_trig_pulse_shaper_pt (.clk_i(clk), .rst_i(rst), .trig_i(trig), .pulse_o(pt_pulse), .busy_o(pt_busy));

  int n_rise = 0, n_high = 0, n_busy = 0, n_pt = 0, n_ptbusy = 0;
  logic prev_pulse = 1'b0;
  always @(negedge clk) begin
    if (pulse && !prev_pulse) n_rise++;
    n_high   += int'(pulse);
    n_busy   += int'(busy);
    n_pt     += int'(pt_pulse);
    n_ptbusy += int'(pt_busy);
    prev_pulse = pulse;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    trig = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual 0 expected 1");
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s_rise, s_high, s_busy, s_pt, s_ptb;
    int p_on, p_off, b_on, b_off, pt_on;

    // R1 reset state
    do_reset();
    @(negedge clk);
    check("R1 pulse after reset", int'(pulse), 0);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 pass-through pulse after reset", int'(pt_pulse), 0);
    check("R8 pass-through busy after reset", int'(pt_busy), 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      do_reset();
      s_rise = n_rise; s_high = n_high; s_busy = n_busy; s_pt = n_pt; s_ptb = n_ptbusy;
      trig = 1'b1; repeat (VEC[i][0]) @(negedge clk);
      trig = 1'b0; repeat (VEC[i][1]) @(negedge clk);
      if (VEC[i][2] > 0) begin
        trig = 1'b1; repeat (VEC[i][2]) @(negedge clk);
        trig = 1'b0;
      end
      repeat (150) @(negedge clk);
      check($sformatf("R6/R7 row %0d pulse count", i), n_rise - s_rise, VEC[i][3]);
      check($sformatf("R4 row %0d pulse high cycles", i), n_high - s_high, VEC[i][4]);
      check($sformatf("R5 row %0d busy cycles", i), n_busy - s_busy, VEC[i][5]);
      check($sformatf("R2 row %0d pass-through high cycles", i), n_pt - s_pt, VEC[i][6]);
      check($sformatf("R8 row %0d pass-through busy", i), n_ptbusy - s_ptb, 0);
    end

    // R3/R4/R5/R7/R8 timing with a held trigger
    do_reset();
    p_on = -1; p_off = -1; b_on = -1; b_off = -1; pt_on = -1;
    trig = 1'b1;
    for (int k = 1; k <= 160; k++) begin
      @(negedge clk);
      if (pulse && p_on < 0) p_on = k;
      if (!pulse && p_on >= 0 && p_off < 0) p_off = k;
      if (busy && b_on < 0) b_on = k;
      if (!busy && b_on >= 0 && b_off < 0) b_off = k;
      if (pt_pulse && pt_on < 0) pt_on = k;
    end
    check("R3 pulse latency", p_on, GL + 3);
    check("R4 pulse contiguous width", p_off - p_on, W);
    check("R5 busy starts with pulse", b_on, p_on);
    check("R5 busy window length", b_off - b_on, W * D);
    check("R7 no retrigger while held", int'(pulse), 0);
    check("R8 pass-through latency", pt_on, GL + 2);
    trig = 1'b0;
    repeat (20) @(negedge clk);

    // R1 reset in mid-pulse
    do_reset();
    trig = 1'b1;
    repeat (GL + 8) @(negedge clk);
    check("R1 pulse high before reset", int'(pulse), 1);
    trig = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R1 pulse cleared by reset", int'(pulse), 0);
    check("R1 busy cleared by reset", int'(busy), 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check("R1 stays idle after reset", int'(busy), 0);
    trig = 1'b1;
    repeat (GL + 4) @(negedge clk);
    check("R1 new trigger accepted after reset", int'(pulse), 1);
    trig = 1'b0;
    repeat (120) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule